// File: doc/BRIEF.md
# Cell payload pattern generator

This block fills the 48-byte payload field of outgoing cells. It offers one byte at a time on a valid/ready stream, marks the first and last byte of each payload, and moves to the next byte only when the consumer accepts the current one. Each payload is built from a selectable source: a captured departure time, one of several pseudo-random bit sequences, a fixed or alternating user byte, or a byte that counts upwards. The cell header, header check, scheduling and line coding are produced elsewhere. This block supplies only the payload bytes.

The source and its settings are taken at the first byte of each payload and held for the rest of that payload, so the configuration may be changed at any time. When an adaptation option is enabled, byte 0 carries a sequence and protection byte. The selected pattern then occupies the remaining 47 bytes. A one-cycle error request inverts one bit of the next pseudo-random byte that leaves the block.

Top module: `cellpay_gen`

## Requirements
- R1: While `rst_n` is low, `out_valid` is low. From the first clock edge after reset it stays high. Each payload has `CELL_BYTES` (48) bytes. `out_sop` marks byte 0 and `out_eop` marks byte 47. The position advances only on a cycle where `out_valid` and `out_ready` are both high.
- R2: While a byte other than byte 0 waits with `out_ready` low, `out_data` does not change, unless `err_inj` is high in that cycle.
- R3: `cfg_mode`, `cfg_user` and `cfg_aal1` are sampled when byte 0 is accepted and held until the payload ends. Changes made in the middle of a payload have no effect until the next one.
- R4: Mode 0 (timestamp). A 32-bit counter increments on each cycle with `tick_100ns` high. Its value when byte 0 is accepted is sent most significant byte first in pattern positions 0 to 3. Every later pattern position is 00h.
- R5: Modes 1, 2, 3 and 4 are continuous pseudo-random sequences: x^9+x^5+1, x^15+x^14+1, x^15+x^14+1 sent inverted, and x^23+x^18+1. Each generator starts at all ones. The new bit is the XOR of state bits N-1 and T-1 and is shifted in at bit 0. Eight new bits make one byte, first bit in bit 7. Each generator moves forward only when one of its own bytes is accepted, so the sequence carries on across payloads. Modes 2 and 3 share one state.
- R6: Mode 5 uses the x^9+x^5+1 sequence but restarts from all ones at pattern position 0 of every payload.
- R7: Mode 6 sends `cfg_user` in every pattern position. Mode 7 sends AAh at even pattern positions and 55h at odd ones. Mode 8 does the same with FFh and 00h.
- R8: Mode 9 sends the pattern position itself (0, 1, 2, ...) as the byte value.
- R9: With `cfg_aal1` set, byte 0 is {CSI, SN[2:0], CRC[2:0], P}. CSI is `cfg_csi`. SN is a 3-bit count of such payloads, starting at 0 after reset. CRC is the remainder of {CSI,SN}·x^3 modulo x^3+x+1. P makes the byte's number of ones even. Pattern position p is byte p+1. Without `cfg_aal1`, pattern position p is byte p.
- R10: An `err_inj` pulse inverts bit 7 of the next byte accepted in a pseudo-random mode (modes 1 to 5) that is not the adaptation byte, counting from the cycle of the pulse. The request waits through any bytes of other modes. One request flips exactly one byte, and it does not disturb the generator state.
- R11: Mode codes 10 to 15 send 00h in every pattern position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_100ns | input | 1 | Timestamp advance enable, one pulse per 100 ns |
| cfg_mode | input | 4 | Payload source code |
| cfg_user | input | 8 | User byte for mode 6 |
| cfg_aal1 | input | 1 | Insert sequence/protection byte at byte 0 |
| cfg_csi | input | 1 | CSI bit for the inserted byte |
| err_inj | input | 1 | Single-bit error request |
| out_ready | input | 1 | Consumer accepts the byte offered |
| out_valid | output | 1 | Byte offered |
| out_data | output | 8 | Payload byte |
| out_sop | output | 1 | Byte 0 of a payload |
| out_eop | output | 1 | Byte 47 of a payload |

## Verification
A wrong byte position shows up at once: `out_sop` and `out_eop` land on the wrong accepted byte, and every expected pattern position after it shifts. If a generator state advances on another mode's bytes, or fails to restart, its next accepted byte diverges from the bench's own sequence. Because the sequences have long periods, such an error is never masked later. A lost or repeated error request shows as a missing or extra flipped bit 7 on the next pseudo-random byte. A wrong sequence count breaks the parity or CRC of the next inserted byte.

// File: rtl/cellpay_pkg.sv
package cellpay_pkg;

  localparam int SN_W = 3;
  localparam int PRBS_GENS = 4;
  // generator lengths and second taps: cross 9, cross 15, cross 23, per-cell 9
  localparam int PRBS_N [PRBS_GENS] = '{9, 15, 23, 9};
  localparam int PRBS_T [PRBS_GENS] = '{5, 14, 18, 5};

  typedef enum logic [3:0] {
    MD_TSTAMP  = 4'd0,
    MD_PRBS9   = 4'd1,
    MD_PRBS15  = 4'd2,
    MD_PRBS15N = 4'd3,
    MD_PRBS23  = 4'd4,
    MD_PRBS9C  = 4'd5,
    MD_USER    = 4'd6,
    MD_ALT_AA  = 4'd7,
    MD_ALT_FF  = 4'd8,
    MD_INCR    = 4'd9
  } pay_mode_e;

  // remainder of {csi,sn} * x^3 modulo x^3+x+1, bits fed MSB first
  function automatic logic [2:0] crc3(logic [3:0] d);
    logic [2:0] r;
    logic fb;
    r = 3'b000;
    for (int i = 3; i >= 0; i--) begin
      fb = d[i] ^ r[2];
      r = {r[1:0], 1'b0} ^ (fb ? 3'b011 : 3'b000);
    end
    return r;
  endfunction

  function automatic logic [7:0] sn_byte(logic csi, logic [SN_W-1:0] sn);
    logic [6:0] upper;
    upper = {csi, sn, crc3({csi, sn})};
    return {upper, ^upper};
  endfunction

endpackage

// File: rtl/cellpay_seq.sv
module cellpay_seq #(
  parameter int CELL_BYTES = 48,
  localparam int IDX_W = $clog2(CELL_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  output logic [IDX_W-1:0] byte_idx,
  output logic             sop,
  output logic             eop
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (fire) begin
      idx_q <= (idx_q == IDX_W'(CELL_BYTES - 1)) ? '0 : idx_q + 1'b1;
    end
  end

  assign byte_idx = idx_q;
  assign sop = (idx_q == '0);
  assign eop = (idx_q == IDX_W'(CELL_BYTES - 1));
endmodule

// File: rtl/cellpay_tstamp.sv
module cellpay_tstamp #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            capture,
  output logic [TS_W-1:0] ts_live,
  output logic [TS_W-1:0] ts_held
);
  logic [TS_W-1:0] cnt_q;
  logic [TS_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      held_q <= '0;
    end else begin
      if (tick) cnt_q <= cnt_q + 1'b1;
      if (capture) held_q <= cnt_q;
    end
  end

  assign ts_live = cnt_q;
  assign ts_held = held_q;
endmodule

// File: rtl/cellpay_lfsr.sv
module cellpay_lfsr #(
  parameter int N = 9,
  parameter int T = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       restart,
  output logic [7:0] byte_out
);
  typedef struct packed {
    logic [7:0]   b;
    logic [N-1:0] s;
  } step_t;

  // eight serial steps, new bit = s[N-1]^s[T-1] into bit 0, first bit in MSB
  function automatic step_t step8(logic [N-1:0] s_in);
    step_t r;
    logic nb;
    r.s = s_in;
    r.b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      nb = r.s[N-1] ^ r.s[T-1];
      r.s = {r.s[N-2:0], nb};
      r.b = {r.b[6:0], nb};
    end
    return r;
  endfunction

  logic [N-1:0] st_q;
  logic [N-1:0] base;
  step_t        nxt;

  assign base = restart ? '1 : st_q;
  assign nxt = step8(base);
  assign byte_out = nxt.b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '1;
    end else if (adv) begin
      st_q <= nxt.s;
    end
  end
endmodule

// File: rtl/cellpay_gen.sv
module cellpay_gen
  import cellpay_pkg::*;
#(
  parameter int CELL_BYTES = 48,
  parameter int TS_W = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_100ns,
  input  logic [3:0] cfg_mode,
  input  logic [7:0] cfg_user,
  input  logic       cfg_aal1,
  input  logic       cfg_csi,
  input  logic       err_inj,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sop,
  output logic       out_eop
);
  localparam int IDX_W = $clog2(CELL_BYTES);
  localparam int TS_BYTES = TS_W / 8;

  logic             valid_q;
  logic             fire;
  logic [IDX_W-1:0] byte_idx;
  logic             sop, eop;

  // per-payload configuration
  logic [3:0] mode_q, mode_now;
  logic [7:0] user_q, user_now;
  logic       aal_q, aal_now;

  logic             is_sn;
  logic [IDX_W-1:0] pos;
  logic             pos0;
  logic [SN_W-1:0]  sn_q;

  logic [TS_W-1:0]  ts_live, ts_held;
  logic [7:0]       ts_byte;

  logic             prbs_mode;
  logic [1:0]       prbs_sel;
  logic [PRBS_GENS-1:0] gen_adv;
  logic [7:0]       gen_byte [PRBS_GENS];

  logic       err_pend_q, err_now, err_hit;
  logic [7:0] pat_byte;

  assign fire = valid_q & out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= 1'b1;
  end

  cellpay_seq #(.CELL_BYTES(CELL_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .byte_idx(byte_idx), .sop(sop), .eop(eop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MD_TSTAMP;
      user_q <= 8'h00;
      aal_q  <= 1'b0;
    end else if (fire && sop) begin
      mode_q <= cfg_mode;
      user_q <= cfg_user;
      aal_q  <= cfg_aal1;
    end
  end

  assign mode_now = sop ? cfg_mode : mode_q;
  assign user_now = sop ? cfg_user : user_q;
  assign aal_now  = sop ? cfg_aal1 : aal_q;

  assign is_sn = aal_now & sop;
  assign pos   = byte_idx - IDX_W'(aal_now);
  assign pos0  = !is_sn && (pos == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)               sn_q <= '0;
    else if (fire && is_sn)   sn_q <= sn_q + 1'b1;
  end

  cellpay_tstamp #(.TS_W(TS_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .tick(tick_100ns), .capture(fire && sop),
    .ts_live(ts_live), .ts_held(ts_held)
  );

  always_comb begin
    logic [TS_W-1:0] src;
    src = sop ? ts_live : ts_held;
    if (pos < IDX_W'(TS_BYTES)) ts_byte = 8'(src >> (8 * (TS_BYTES - 1 - int'(pos))));
    else                        ts_byte = 8'h00;
  end

  always_comb begin
    prbs_mode = 1'b1;
    prbs_sel  = 2'd0;
    unique case (mode_now)
      MD_PRBS9:             prbs_sel = 2'd0;
      MD_PRBS15, MD_PRBS15N: prbs_sel = 2'd1;
      MD_PRBS23:            prbs_sel = 2'd2;
      MD_PRBS9C:            prbs_sel = 2'd3;
      default:              prbs_mode = 1'b0;
    endcase
  end

  for (genvar k = 0; k < PRBS_GENS; k++) begin : g_gen
    localparam bit RESTARTS = (k == PRBS_GENS - 1);
    assign gen_adv[k] = fire && !is_sn && prbs_mode && (prbs_sel == 2'(k));
    cellpay_lfsr #(.N(PRBS_N[k]), .T(PRBS_T[k])) u_lfsr (
      .clk(clk), .rst_n(rst_n), .adv(gen_adv[k]),
      .restart(RESTARTS && pos0), .byte_out(gen_byte[k])
    );
  end

  assign err_now = err_pend_q | err_inj;
  assign err_hit = fire && !is_sn && prbs_mode && err_now;

  always_ff @(posedge clk) begin
    if (!rst_n) err_pend_q <= 1'b0;
    else        err_pend_q <= err_now & !err_hit;
  end

  always_comb begin
    unique case (mode_now)
      MD_TSTAMP:  pat_byte = ts_byte;
      MD_PRBS9:   pat_byte = gen_byte[0];
      MD_PRBS15:  pat_byte = gen_byte[1];
      MD_PRBS15N: pat_byte = ~gen_byte[1];
      MD_PRBS23:  pat_byte = gen_byte[2];
      MD_PRBS9C:  pat_byte = gen_byte[3];
      MD_USER:    pat_byte = user_now;
      MD_ALT_AA:  pat_byte = pos[0] ? 8'h55 : 8'hAA;
      MD_ALT_FF:  pat_byte = pos[0] ? 8'h00 : 8'hFF;
      MD_INCR:    pat_byte = 8'(pos);
      default:    pat_byte = 8'h00;
    endcase
  end

  always_comb begin
    if (is_sn) out_data = sn_byte(cfg_csi, sn_q);
    else       out_data = pat_byte ^ {(prbs_mode && err_now), 7'b0};
  end

  assign out_valid = valid_q;
  assign out_sop   = sop;
  assign out_eop   = eop;
endmodule

// File: rtl/cellpay_gen_chk.sv
module cellpay_gen_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_sop,
  input logic             out_eop,
  input logic [7:0]       out_data,
  input logic             err_inj,
  input logic [IDX_W-1:0] byte_idx,
  input logic             aal_now,
  input logic             err_pend_q,
  input logic             err_hit
);
  // R1
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);
  // R1
  sop_eop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_sop && out_eop));
  // R1
  eop_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eop) |=> out_sop);
  // R1
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(byte_idx));
  // R2
  stall_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !out_sop) |=> (err_inj || $stable(out_data)));
  // R9
  sn_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop && aal_now) |-> ($countones(out_data) % 2 == 0));
  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit |=> !err_pend_q);
  // R10
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pend_q && !err_hit) |=> err_pend_q);
endmodule

bind cellpay_gen cellpay_gen_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data), .err_inj(err_inj),
  .byte_idx(byte_idx), .aal_now(aal_now), .err_pend_q(err_pend_q), .err_hit(err_hit)
);

// File: tb/cellpay_gen_tb.sv
module cellpay_gen_tb;
  localparam int CLK_P = 10;
  localparam int NB = 48;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_100ns = 1'b0;
  logic [3:0] cfg_mode = 4'd6;
  logic [7:0] cfg_user = 8'h00;
  logic       cfg_aal1 = 1'b0;
  logic       cfg_csi = 1'b0;
  logic       err_inj = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_sop, out_eop;

  int checks = 0;
  int errors = 0;

  cellpay_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tick_100ns(tick_100ns), .cfg_mode(cfg_mode),
    .cfg_user(cfg_user), .cfg_aal1(cfg_aal1), .cfg_csi(cfg_csi), .err_inj(err_inj),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop)
  );

  always #(CLK_P/2) clk = ~clk;

  // bench model state
  int          m_idx = 0;
  logic [3:0]  m_mode;
  logic [7:0]  m_user;
  logic        m_aal;
  logic [31:0] m_ts_cap;
  logic [31:0] ticks = 0;
  logic [2:0]  m_sn = 0;
  logic [22:0] ms [4];
  logic        m_pend = 0;
  int          cyc = 0;
  int          cells_done = 0;
  logic        prev_stall = 0;
  logic [7:0]  prev_data;
  int          flips = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int gen_n(int k);
    return (k == 0 || k == 3) ? 9 : (k == 1 ? 15 : 23);
  endfunction
  function automatic int gen_t(int k);
    return (k == 0 || k == 3) ? 5 : (k == 1 ? 14 : 18);
  endfunction

  function automatic logic [7:0] pbyte(int k);
    logic [7:0] b = 0;
    int n = gen_n(k);
    int t = gen_t(k);
    for (int i = 0; i < 8; i++) begin
      logic nb;
      nb = ms[k][n-1] ^ ms[k][t-1];
      ms[k] = ((ms[k] << 1) | 23'(nb)) & ((23'h7FFFFF) >> (23 - n));
      b = {b[6:0], nb};
    end
    return b;
  endfunction

  // long division of {csi,sn,000} by 1011
  function automatic logic [7:0] exp_sn(logic csi, logic [2:0] sn);
    logic [6:0] v;
    logic [6:0] hi;
    v = {csi, sn, 3'b000};
    for (int i = 6; i >= 3; i--) if (v[i]) v = v ^ (7'b1011 << (i - 3));
    hi = {csi, sn, v[2:0]};
    return {hi, ($countones(hi) % 2 == 1)};
  endfunction

  function automatic string mtag(logic [3:0] m);
    case (m)
      4'd0: return "R4";
      4'd1, 4'd2, 4'd3, 4'd4: return "R5";
      4'd5: return "R6";
      4'd6, 4'd7, 4'd8: return "R7";
      4'd9: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic one_cycle();
    @(negedge clk);
    out_ready  = ((cyc % 7) != 3) && ((cyc % 11) != 5);
    tick_100ns = (cyc % 3) == 1;
    err_inj    = (cyc % 37) == 11;
    #1;
    if (err_inj) m_pend = 1;
    chk(out_valid == 1'b1, "R1 valid", out_valid, 1);
    if (prev_stall && m_idx != 0 && !err_inj)
      chk(out_data == prev_data, "R2 stall", out_data, prev_data);
    if (out_ready) begin
      logic [7:0] e;
      int p;
      bit prbs;
      string tg;
      if (m_idx == 0) begin
        m_mode = cfg_mode; m_user = cfg_user; m_aal = cfg_aal1; m_ts_cap = ticks;
      end
      chk(out_sop == (m_idx == 0), "R1 sop", out_sop, m_idx == 0);
      chk(out_eop == (m_idx == NB-1), "R1 eop", out_eop, m_idx == NB-1);
      if (m_aal && m_idx == 0) begin
        e = exp_sn(cfg_csi, m_sn);
        m_sn++;
        chk(out_data == e, "R9 sn byte", out_data, e);
      end else begin
        p = m_idx - int'(m_aal);
        prbs = 0;
        tg = mtag(m_mode);
        case (m_mode)
          4'd0: e = (p < 4) ? m_ts_cap[8*(3-p) +: 8] : 8'h00;
          4'd1: begin e = pbyte(0); prbs = 1; end
          4'd2: begin e = pbyte(1); prbs = 1; end
          4'd3: begin e = ~pbyte(1); prbs = 1; end
          4'd4: begin e = pbyte(2); prbs = 1; end
          4'd5: begin if (p == 0) ms[3] = 23'h1FF; e = pbyte(3); prbs = 1; end
          4'd6: e = m_user;
          4'd7: e = p[0] ? 8'h55 : 8'hAA;
          4'd8: e = p[0] ? 8'h00 : 8'hFF;
          4'd9: e = 8'(p);
          default: e = 8'h00;
        endcase
        if (prbs && m_pend) begin
          e = e ^ 8'h80; m_pend = 0; flips++; tg = "R10";
        end
        chk(out_data == e, tg, out_data, e);
      end
      if (m_idx == NB-1) cells_done++;
      m_idx = (m_idx + 1) % NB;
    end
    prev_stall = !out_ready;
    prev_data  = out_data;
    if (tick_100ns) ticks++;
    cyc++;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ms[0] = 23'h1FF; ms[1] = 23'h7FFF; ms[2] = 23'h7FFFFF; ms[3] = 23'h1FF;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int md = 0; md < 12; md++) begin
      for (int a = 0; a < 2; a++) begin
        cfg_mode = 4'(md);
        cfg_aal1 = a[0];
        cfg_user = 8'h5A + 8'(md * 17);
        cfg_csi  = md[0] ^ a[0];
        cells_done = 0;
        while (cells_done < 3) begin
          // R3: disturb configuration mid-payload, restore before the end
          if (m_idx == 20) begin
            cfg_mode = 4'((md + 3) % 12); cfg_user = ~cfg_user; cfg_aal1 = ~cfg_aal1;
          end
          if (m_idx == 40) begin
            cfg_mode = 4'(md); cfg_user = 8'h5A + 8'(md * 17); cfg_aal1 = a[0];
          end
          one_cycle();
        end
      end
    end
    // R10: a request made during timestamp payloads must land on the next PRBS byte
    chk(flips > 0, "R10 flips seen", flips, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule